// File: doc/BRIEF.md
# Dual-Clock Width-Converting First-Word-Fall-Through FIFO

This block moves 36-bit entries from a write port clocked by `clk_a_i` to a read port clocked by `clk_b_i`. The two clocks are unrelated. The read side works in first-word-fall-through fashion. As soon as an entry reaches an empty queue, it is loaded into a port B output register and an output-ready flag rises. The reader can then consume the data without first issuing a request.

Port B can present each stored entry in three ways: whole (36 bits), as two 18-bit halves, or as four 9-bit bytes. In the two narrow modes the pieces come out most significant first, right-aligned on `data_b_o`. A piece counter moves to the next entry only after the last piece of the current one has been read. Each port qualifies its accesses with four strobes: an active-low select, a direction bit, an enable and a side-channel select.

The pointers cross between the clock domains as Gray code through two-flop synchronizers. A full flag is reported in the port A domain. Depth is a parameter and must be a power of two.

Top module: `bm_fifo`

## Requirements
- R1: A write stores `data_a_i` on a rising `clk_a_i` edge only when `cs_a_ni`=0, `wr_a_i`=1, `en_a_i`=1, `mbx_a_i`=0 and `full_a_o`=0; any other combination stores nothing.
- R2: A read occurs on a rising `clk_b_i` edge only when `cs_b_ni`=0, `wr_b_i`=0, `en_b_i`=1, `mbx_b_i`=0 and `ready_b_o`=1; otherwise the output and piece position are unchanged.
- R3: An entry written into an empty FIFO appears on `data_b_o` with `ready_b_o` high after the third rising `clk_b_i` edge that follows the write edge. If the write edge falls too close before a `clk_b_i` edge, this happens one edge later.
- R4: Entries are delivered in write order, none lost or duplicated.
- R5: With `bus_size_i`=2'b00 each read consumes one whole entry, shown on `data_b_o[35:0]`.
- R6: With `bus_size_i`=2'b01 an entry takes two reads: bits 35:18 first, then 17:0, each on `data_b_o[17:0]` with bits 35:18 zero.
- R7: With `bus_size_i`=2'b10 an entry takes four reads: bits 35:27, 26:18, 17:9, 8:0 in that order, on `data_b_o[8:0]` with bits 35:9 zero.
- R8: `ready_b_o` falls only on the read of the last piece of an entry when no further entry is available; it never falls in the middle of an entry.
- R9: Read requests while `ready_b_o` is low are ignored and do not advance the piece position.
- R10: `full_a_o` is high when the storage array holds DEPTH entries not yet moved to the output register; writes while full are dropped.
- R11: After `rst_ni` is asserted, `ready_b_o` and `full_a_o` are low and the FIFO is empty.
- R12: While `ready_b_o` is high and no read occurs, `data_b_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Write port clock |
| clk_b_i | input | 1 | Read port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_a_ni | input | 1 | Port A select, active low |
| wr_a_i | input | 1 | Port A direction, 1 = write |
| en_a_i | input | 1 | Port A enable |
| mbx_a_i | input | 1 | Port A side-channel select, must be 0 for FIFO access |
| data_a_i | input | 36 | Write data |
| full_a_o | output | 1 | FIFO full, port A domain |
| cs_b_ni | input | 1 | Port B select, active low |
| wr_b_i | input | 1 | Port B direction, 0 = read |
| en_b_i | input | 1 | Port B enable |
| mbx_b_i | input | 1 | Port B side-channel select, must be 0 for FIFO access |
| bus_size_i | input | 2 | Port B width: 00 = 36, 01 = 18, 10 = 9 bits |
| data_b_o | output | 36 | Output register piece, right-aligned |
| ready_b_o | output | 1 | Output ready, port B domain |

## Verification
The bench measures fall-through latency into an empty FIFO edge by edge. A design with a missing or extra synchronizer stage shows data one edge early or late.

In the two narrow modes it reads one entry piece by piece. A wrong piece order would swap halves or bytes, and a flag tied to entries rather than pieces would drop ready after the first half.

It fills the array to its full mark and offers one more word. An overflow would then surface as an extra or corrupt entry during the drain.

Random traffic adds wrong-strobe accesses on both ports and reads while not ready. A decoder that ignores one strobe would insert or skip entries in the checked stream.

// File: rtl/bm_fifo_pkg.sv
package bm_fifo_pkg;
  typedef enum logic [1:0] {
    BUS_LONG = 2'b00,
    BUS_WORD = 2'b01,
    BUS_BYTE = 2'b10
  } bus_size_e;

  localparam int unsigned ENTRY_W = 36;
  localparam int unsigned HALF_W  = 18;
  localparam int unsigned BYTE_W  = 9;
endpackage

// File: rtl/bm_ptr_sync.sv
module bm_ptr_sync #(
  parameter int unsigned W      = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] gray_o,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= gray_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign gray_o = stg_q[STAGES-1];

  always_comb
    for (int i = 0; i < W; i++) bin_o[i] = ^(gray_o >> i);
endmodule

// File: rtl/bm_wr_ctrl.sv
module bm_wr_ctrl #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic [PW-1:0] rptr_bin_i,
  output logic          wr_en_o,
  output logic [PW-1:0] wptr_bin_o,
  output logic [PW-1:0] wptr_gray_o,
  output logic          full_o
);
  logic [PW-1:0] wptr_q, wptr_nxt, wgray_q;

  assign full_o     = (wptr_q - rptr_bin_i) == PW'(DEPTH);
  assign wr_en_o    = wr_req_i & ~full_o;
  assign wptr_nxt   = wptr_q + PW'(wr_en_o);
  assign wptr_bin_o = wptr_q;
  assign wptr_gray_o = wgray_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else begin
      wptr_q  <= wptr_nxt;
      wgray_q <= wptr_nxt ^ (wptr_nxt >> 1);
    end
endmodule

// File: rtl/bm_rd_ctrl.sv
module bm_rd_ctrl
  import bm_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_req_i,
  input  logic [1:0]         bus_size_i,
  input  logic [PW-1:0]      wptr_bin_i,
  input  logic [ENTRY_W-1:0] mem_data_i,
  output logic [PW-1:0]      rptr_bin_o,
  output logic [PW-1:0]      rptr_gray_o,
  output logic [ENTRY_W-1:0] data_o,
  output logic               ready_o,
  output logic [1:0]         sub_o,
  output logic               last_o
);
  logic [PW-1:0]      rptr_q, rptr_nxt, rgray_q;
  logic [ENTRY_W-1:0] out_q;
  logic               ready_q;
  logic [1:0]         sub_q;
  logic               fire, pop, load, avail;

  always_comb
    case (bus_size_i)
      BUS_WORD: last_o = (sub_q == 2'd1);
      BUS_BYTE: last_o = (sub_q == 2'd3);
      default:  last_o = 1'b1;
    endcase

  assign fire     = rd_req_i & ready_q;
  assign pop      = fire & last_o;
  assign avail    = (rptr_q != wptr_bin_i);
  // fall-through load when the register is free or being emptied this edge
  assign load     = (~ready_q | pop) & avail;
  assign rptr_nxt = rptr_q + PW'(load);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      out_q   <= '0;
      ready_q <= 1'b0;
      sub_q   <= '0;
    end else begin
      rptr_q  <= rptr_nxt;
      rgray_q <= rptr_nxt ^ (rptr_nxt >> 1);
      if (fire) sub_q <= last_o ? 2'd0 : sub_q + 2'd1;
      if (load) begin
        out_q   <= mem_data_i;
        ready_q <= 1'b1;
      end else if (pop) begin
        ready_q <= 1'b0;
      end
    end

  always_comb begin
    data_o = '0;
    case (bus_size_i)
      BUS_WORD: data_o[HALF_W-1:0] = sub_q[0] ? out_q[HALF_W-1:0] : out_q[ENTRY_W-1:HALF_W];
      BUS_BYTE:
        case (sub_q)
          2'd0:    data_o[BYTE_W-1:0] = out_q[35:27];
          2'd1:    data_o[BYTE_W-1:0] = out_q[26:18];
          2'd2:    data_o[BYTE_W-1:0] = out_q[17:9];
          default: data_o[BYTE_W-1:0] = out_q[8:0];
        endcase
      default: data_o = out_q;
    endcase
  end

  assign rptr_bin_o  = rptr_q;
  assign rptr_gray_o = rgray_q;
  assign ready_o     = ready_q;
  assign sub_o       = sub_q;
endmodule

// File: rtl/bm_fifo.sv
module bm_fifo
  import bm_fifo_pkg::*;
#(
  parameter int unsigned DEPTH       = 256,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_a_i,
  input  logic        clk_b_i,
  input  logic        rst_ni,
  input  logic        cs_a_ni,
  input  logic        wr_a_i,
  input  logic        en_a_i,
  input  logic        mbx_a_i,
  input  logic [35:0] data_a_i,
  output logic        full_a_o,
  input  logic        cs_b_ni,
  input  logic        wr_b_i,
  input  logic        en_b_i,
  input  logic        mbx_b_i,
  input  logic [1:0]  bus_size_i,
  output logic [35:0] data_b_o,
  output logic        ready_b_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic               wr_req, wr_en, rd_req, last_piece;
  logic [1:0]         sub_idx;
  logic [PW-1:0]      wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [PW-1:0]      wptr_bin_b, wptr_gray_b, rptr_bin_a, rptr_gray_a;
  logic [ENTRY_W-1:0] mem [DEPTH];

  assign wr_req = ~cs_a_ni &  wr_a_i & en_a_i & ~mbx_a_i;
  assign rd_req = ~cs_b_ni & ~wr_b_i & en_b_i & ~mbx_b_i;

  always_ff @(posedge clk_a_i)
    if (wr_en) mem[wptr_bin[AW-1:0]] <= data_a_i;

  bm_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i       (clk_a_i),
    .rst_ni      (rst_ni),
    .wr_req_i    (wr_req),
    .rptr_bin_i  (rptr_bin_a),
    .wr_en_o     (wr_en),
    .wptr_bin_o  (wptr_bin),
    .wptr_gray_o (wptr_gray),
    .full_o      (full_a_o)
  );

  bm_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2b (
    .clk_i  (clk_b_i),
    .rst_ni (rst_ni),
    .gray_i (wptr_gray),
    .gray_o (wptr_gray_b),
    .bin_o  (wptr_bin_b)
  );

  bm_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2a (
    .clk_i  (clk_a_i),
    .rst_ni (rst_ni),
    .gray_i (rptr_gray),
    .gray_o (rptr_gray_a),
    .bin_o  (rptr_bin_a)
  );

  bm_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk_i       (clk_b_i),
    .rst_ni      (rst_ni),
    .rd_req_i    (rd_req),
    .bus_size_i  (bus_size_i),
    .wptr_bin_i  (wptr_bin_b),
    .mem_data_i  (mem[rptr_bin[AW-1:0]]),
    .rptr_bin_o  (rptr_bin),
    .rptr_gray_o (rptr_gray),
    .data_o      (data_b_o),
    .ready_o     (ready_b_o),
    .sub_o       (sub_idx),
    .last_o      (last_piece)
  );
endmodule

// File: rtl/bm_fifo_chk.sv
module bm_fifo_chk #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned PW   = $clog2(DEPTH) + 1
) (
  input logic          clk_a_i,
  input logic          clk_b_i,
  input logic          rst_ni,
  input logic          wr_req,
  input logic          full,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rptr_a,
  input logic          rd_req,
  input logic          ready,
  input logic [1:0]    sub,
  input logic          last,
  input logic [35:0]   data_b
);
  a_r10_full_blocks_write: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (wr_req && full) |=> $stable(wptr));

  a_r10_occupancy_bound: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (PW'(wptr - rptr_a) <= PW'(DEPTH)));

  // R4: write pointer crosses domains with one bit changing per step
  a_r4_gray_single_step: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    $onehot0(wgray ^ $past(wgray)));

  a_r9_idle_read_ignored: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (rd_req && !ready) |=> $stable(sub));

  a_r8_ready_holds_mid_entry: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (rd_req && ready && !last) |=> ready);

  a_r8_ready_fall_cause: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    $fell(ready) |-> $past(rd_req && last));

  a_r12_hold_output: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (ready && !rd_req) |=> $stable(data_b));
endmodule

bind bm_fifo bm_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_a_i (clk_a_i),
  .clk_b_i (clk_b_i),
  .rst_ni  (rst_ni),
  .wr_req  (wr_req),
  .full    (full_a_o),
  .wptr    (wptr_bin),
  .wgray   (wptr_gray),
  .rptr_a  (rptr_bin_a),
  .rd_req  (rd_req),
  .ready   (ready_b_o),
  .sub     (sub_idx),
  .last    (last_piece),
  .data_b  (data_b_o)
);

// File: tb/sim_bm_fifo.sv
`timescale 1ns/1ps
module sim_bm_fifo;
  localparam int unsigned DEPTH = 16;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic cs_a_n = 1'b1, wr_a = 1'b0, en_a = 1'b0, mbx_a = 1'b0;
  logic cs_b_n = 1'b1, wr_b = 1'b1, en_b = 1'b0, mbx_b = 1'b0;
  logic [35:0] data_a = '0;
  logic [1:0]  bus_size = 2'b00;
  logic [35:0] data_b;
  logic        full_a, ready_b;

  int checks = 0, errors = 0;
  logic [35:0] q[$];
  int sub_m = 0;

  bm_fifo #(.DEPTH(DEPTH)) u0 (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .cs_a_ni(cs_a_n), .wr_a_i(wr_a), .en_a_i(en_a), .mbx_a_i(mbx_a),
    .data_a_i(data_a), .full_a_o(full_a),
    .cs_b_ni(cs_b_n), .wr_b_i(wr_b), .en_b_i(en_b), .mbx_b_i(mbx_b),
    .bus_size_i(bus_size), .data_b_o(data_b), .ready_b_o(ready_b)
  );

  initial begin #7; forever #10 clk_a = ~clk_a; end   // 50 MHz
  initial forever #15 clk_b = ~clk_b;

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pieces(input logic [1:0] m);
    return (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 1;
  endfunction

  function automatic logic [35:0] piece(input logic [35:0] e, input logic [1:0] m, input int s);
    if (m == 2'b01) return (s == 0) ? {18'b0, e[35:18]} : {18'b0, e[17:0]};
    if (m == 2'b10)
      case (s)
        0: return {27'b0, e[35:27]};
        1: return {27'b0, e[26:18]};
        2: return {27'b0, e[17:9]};
        default: return {27'b0, e[8:0]};
      endcase
    return e;
  endfunction

  function automatic string mode_tag(input logic [1:0] m);
    return (m == 2'b01) ? "R6 R4" : (m == 2'b10) ? "R7 R4" : "R5 R4";
  endfunction

  // R1: valid write strobes
  task automatic do_write(input logic [35:0] d);
    bit acc;
    @(negedge clk_a);
    acc = !full_a;
    cs_a_n = 0; wr_a = 1; en_a = 1; mbx_a = 0; data_a = d;
    @(posedge clk_a); #1;
    cs_a_n = 1; en_a = 0;
    if (acc) q.push_back(d);
  endtask

  // R1: one strobe wrong, nothing may be stored
  task automatic bad_write(input logic [35:0] d);
    int k = int'($urandom_range(0, 3));
    @(negedge clk_a);
    cs_a_n = (k == 0); wr_a = (k != 1); en_a = (k != 2); mbx_a = (k == 3); data_a = d;
    @(posedge clk_a); #1;
    cs_a_n = 1; en_a = 0; mbx_a = 0;
  endtask

  task automatic do_read();
    bit rdy;
    @(negedge clk_b);
    rdy = ready_b;
    if (rdy) begin
      check(q.size() > 0, "R8 ready with no entry", 36'(ready_b), 36'(0));
      if (q.size() > 0) check(data_b === piece(q[0], bus_size, sub_m), mode_tag(bus_size),
                              data_b, piece(q[0], bus_size, sub_m));
    end
    cs_b_n = 0; wr_b = 0; en_b = 1; mbx_b = 0;
    @(posedge clk_b); #1;
    cs_b_n = 1; en_b = 0;
    if (rdy && q.size() > 0) begin
      if (sub_m == pieces(bus_size) - 1) begin sub_m = 0; void'(q.pop_front()); end
      else sub_m++;
    end else if (!rdy) begin
      // R9: a read while not ready must not move the piece position
      @(negedge clk_b);
      if (ready_b && q.size() > 0)
        check(data_b === piece(q[0], bus_size, sub_m), "R9", data_b, piece(q[0], bus_size, sub_m));
    end
  endtask

  // R2 R12: strobe wrong or idle, output must hold
  task automatic bad_read();
    int k = int'($urandom_range(0, 4));
    bit rdy;
    logic [35:0] held;
    @(negedge clk_b);
    rdy = ready_b; held = data_b;
    cs_b_n = (k == 0); wr_b = (k == 1); en_b = (k != 2 && k != 4); mbx_b = (k == 3);
    @(posedge clk_b); #1;
    cs_b_n = 1; en_b = 0; mbx_b = 0; wr_b = 1;
    @(negedge clk_b);
    if (rdy) check(ready_b && data_b === held, "R2 R12", data_b, held);
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && (q.size() > 0 || ready_b); i++) do_read();
    repeat (8) @(negedge clk_b);
    check(!ready_b && q.size() == 0, "R1 R4 R8 entries left after drain", 36'(q.size()), 36'(0));
  endtask

  initial begin
    int cnt;
    logic [35:0] w;
    void'($urandom(32'd20240611));
    #3;
    check(!ready_b && !full_a, "R11 in reset", {34'b0, ready_b, full_a}, 36'd0);
    #97 rst_n = 1;
    repeat (3) @(negedge clk_b);
    check(!ready_b && !full_a, "R11 after reset", {34'b0, ready_b, full_a}, 36'd0);

    // R3: fall-through latency into an empty FIFO
    w = 36'h9_8765_4321;
    @(negedge clk_a);
    cs_a_n = 0; wr_a = 1; en_a = 1; mbx_a = 0; data_a = w;
    @(posedge clk_a); #1;
    cs_a_n = 1; en_a = 0;
    q.push_back(w);
    cnt = 0;
    while (!ready_b && cnt < 8) begin @(posedge clk_b); #1; cnt++; end
    check(cnt == 3, "R3 latency in clk_b edges", 36'(cnt), 36'd3);
    check(data_b === w, "R3 data", data_b, w);
    drain();

    // R8 R7: byte mode, ready must hold until the fourth piece
    bus_size = 2'b10;
    do_write(36'hA_BCDE_F012);
    repeat (10) @(negedge clk_b);
    for (int i = 0; i < 4; i++) begin
      do_read();
      @(negedge clk_b);
      check(ready_b == (i < 3), "R8 ready during byte reads", 36'(ready_b), 36'(i < 3));
    end
    // R6: word mode, two halves
    bus_size = 2'b01;
    do_write(36'h1_2345_6789);
    do_write(36'hF_EDCB_A987);
    repeat (10) @(negedge clk_b);
    drain();

    // R10: fill memory while one entry sits in the output register
    bus_size = 2'b00;
    do_write(36'h0_0000_0001);
    repeat (12) @(negedge clk_a);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk_a);
      check(!full_a, "R10 not full early", 36'(full_a), 36'd0);
      do_write(36'h1_0000_0000 + 36'(i));
    end
    @(negedge clk_a);
    check(full_a, "R10 full at DEPTH", 36'(full_a), 36'd1);
    do_write(36'h5_A5A5_A5A5);   // must be dropped, model does not push
    drain();

    // random traffic in every port B width
    for (int m = 0; m < 3; m++) begin
      bus_size = 2'(m);
      fork
        for (int i = 0; i < 500; i++)
          if ($urandom_range(0, 99) < 65) do_write({$urandom, 4'($urandom)});
          else bad_write({$urandom, 4'($urandom)});
        for (int i = 0; i < 900; i++)
          if ($urandom_range(0, 99) < 70) do_read();
          else bad_read();
      join
      drain();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule